// File: doc/BRIEF.md
# Consecutive-Match Result Comparator

This block watches the stream of finished conversion results from an analog-to-digital converter. Each result arrives as a one-cycle strobe with a channel number and a 10-bit value. A parameterized number of comparator units (two by default) each watch one chosen channel. A unit tests every result from that channel against a programmed threshold. A result can qualify as "below the threshold" or as "at or above the threshold".

A unit does not react to one qualifying result. It raises its sticky flag only after a programmed run of N qualifying results from its channel with no failing result between them. N is stored in its configuration word as N−1. The flag stays set until software clears it with a write-one pulse. An interrupt output per unit follows the flag whenever that unit's interrupt enable is set. Producing the conversions and the register bus are left to neighbouring logic, which drives the configuration-write and clear strobes directly.

Top module: `rcmp_top`

## Requirements
- R1: After reset every flag and every interrupt output is 0, and every unit holds an all-zero configuration, so every unit is disabled.
- R2: A configuration word written with `cfg_we[u]` uses this bit layout (default widths):
  - bit 0: enable
  - bit 1: interrupt enable
  - bit 2: condition
  - bits 5:3: channel
  - bits 15:6: threshold
  - bits 19:16: run length minus one
- R3: With condition 0 a result qualifies when value < threshold. With condition 1 it qualifies when value >= threshold. A value equal to the threshold qualifies only under condition 1.
- R4: When the run length field holds N−1 (N from 1 to 16), the flag is 1 in the cycle after the Nth consecutive qualifying result from the selected channel, and not before.
- R5: A result from the selected channel that does not qualify resets the run count to zero.
- R6: Results from any other channel leave the run count unchanged.
- R7: The flag is sticky: later results, whether they qualify or fail, do not clear it. When the flag is raised the run count restarts from zero, so another full run of N is needed to raise it again.
- R8: A 1 on `flag_clr[u]` clears that unit's flag in the next cycle. If a run completes in the same cycle as the clear, the flag stays 1.
- R9: `irq[u]` is 1 exactly when that unit's flag is 1 and its interrupt enable bit is 1.
- R10: Any configuration write resets the run count to zero, and a result in the same cycle as the write is not counted. While the enable bit is 0, no result changes the count or raises the flag.
- R11: Units are independent: the results, writes and clears aimed at one unit do not change another unit's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | One-cycle strobe marking a finished result |
| res_chan | input | CH_W (3) | Channel of the result |
| res_data | input | DATA_W (10) | Result value |
| cfg_we | input | UNITS (2) | Per-unit configuration write strobe |
| cfg_data | input | CFG_W (20) | Configuration word, layout per R2 |
| flag_clr | input | UNITS (2) | Per-unit write-one flag clear |
| flag | output | UNITS (2) | Sticky compare flags |
| irq | output | UNITS (2) | Per-unit interrupt |

## Verification
The hardest states to reach from the ports are those where the run count sits partway through a run while something else happens. One case is a run that has been interrupted. Another is a count that has been reset by a fresh configuration write. A third is a run that completes in the same cycle as a clear.

Since the count is not visible, each scenario places the disturbance after a known number of qualifying results. It then sends exactly the number of further hits that should be needed and checks that the flag appears on the last hit and not one earlier. Foreign-channel results are interleaved mid-run to show that they neither advance nor break the run. The flag is also held set while failing results arrive, to show that it stays sticky.

// File: rtl/rcmp_pkg.sv
package rcmp_pkg;
   // Fixed low fields of the configuration word; wider fields follow.
   localparam int EN_BIT   = 0;
   localparam int IE_BIT   = 1;
   localparam int MODE_BIT = 2;
   localparam int CH_LSB   = 3;

   typedef enum logic {
      CMP_BELOW       = 1'b0,
      CMP_AT_OR_ABOVE = 1'b1
   } cmp_mode_e;
endpackage

// File: rtl/rcmp_test.sv
module rcmp_test
   import rcmp_pkg::*;
#(
   parameter int DATA_W = 10
) (
   input  logic [DATA_W-1:0] value,
   input  logic [DATA_W-1:0] thresh,
   input  cmp_mode_e         mode,
   output logic              pass
);
   logic below;
   assign below = (value < thresh);
   assign pass  = (mode == CMP_AT_OR_ABOVE) ? !below : below;
endmodule

// File: rtl/rcmp_unit.sv
module rcmp_unit
   import rcmp_pkg::*;
#(
   parameter int DATA_W = 10,
   parameter int CH_W   = 3,
   parameter int CNT_W  = 4,
   localparam int VAL_LSB = CH_LSB + CH_W,
   localparam int CNT_LSB = VAL_LSB + DATA_W,
   localparam int CFG_W   = CNT_LSB + CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_din,
   input  logic              res_valid,
   input  logic [CH_W-1:0]   res_chan,
   input  logic [DATA_W-1:0] res_data,
   input  logic              flag_clr,
   output logic              flag,
   output logic              irq
);
   logic [CFG_W-1:0]  cfg_q;
   logic [CNT_W-1:0]  run_q;
   logic              en, ie, hit, mine, done;
   logic [CH_W-1:0]   sel_ch;
   logic [DATA_W-1:0] thresh;
   logic [CNT_W-1:0]  run_last;
   cmp_mode_e         mode;

   assign en       = cfg_q[EN_BIT];
   assign ie       = cfg_q[IE_BIT];
   assign mode     = cmp_mode_e'(cfg_q[MODE_BIT]);
   assign sel_ch   = cfg_q[CH_LSB +: CH_W];
   assign thresh   = cfg_q[VAL_LSB +: DATA_W];
   assign run_last = cfg_q[CNT_LSB +: CNT_W];

   rcmp_test #(.DATA_W(DATA_W)) u_test (
      .value  (res_data),
      .thresh (thresh),
      .mode   (mode),
      .pass   (hit)
   );

   assign mine = res_valid && en && (res_chan == sel_ch) && !cfg_we;
   assign done = mine && hit && (run_q == run_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         run_q <= '0;
      end else if (cfg_we) begin
         cfg_q <= cfg_din;
         run_q <= '0;
      end else if (mine) begin
         if (!hit || done) run_q <= '0;
         else              run_q <= run_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (done)     flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
   end

   assign irq = flag && ie;

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !flag_clr |=> flag);
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr && !(res_valid && res_chan == sel_ch && en) && !cfg_we |=> !flag);
   p_cfg_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> run_q == '0);
   p_other_chan_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_chan != sel_ch && !cfg_we |=> $stable(run_q));
   p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(res_valid && res_chan == sel_ch && en));
   p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= run_last);
endmodule

// File: rtl/rcmp_top.sv
module rcmp_top
   import rcmp_pkg::*;
#(
   parameter int UNITS  = 2,
   parameter int DATA_W = 10,
   parameter int CH_W   = 3,
   parameter int CNT_W  = 4,
   localparam int CFG_W = CH_LSB + CH_W + DATA_W + CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [CH_W-1:0]   res_chan,
   input  logic [DATA_W-1:0] res_data,
   input  logic [UNITS-1:0]  cfg_we,
   input  logic [CFG_W-1:0]  cfg_data,
   input  logic [UNITS-1:0]  flag_clr,
   output logic [UNITS-1:0]  flag,
   output logic [UNITS-1:0]  irq
);
   if (UNITS < 1 || UNITS > 32) begin : g_bad_units
      $error("rcmp_top: UNITS must be 1..32");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data
      $error("rcmp_top: DATA_W must be 1..32");
   end
   if (CH_W < 1 || CH_W > 8) begin : g_bad_ch
      $error("rcmp_top: CH_W must be 1..8");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("rcmp_top: CNT_W must be 1..16");
   end

   for (genvar u = 0; u < UNITS; u++) begin : g_unit
      rcmp_unit #(
         .DATA_W (DATA_W),
         .CH_W   (CH_W),
         .CNT_W  (CNT_W)
      ) u_unit (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_we    (cfg_we[u]),
         .cfg_din   (cfg_data),
         .res_valid (res_valid),
         .res_chan  (res_chan),
         .res_data  (res_data),
         .flag_clr  (flag_clr[u]),
         .flag      (flag[u]),
         .irq       (irq[u])
      );
   end

   p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[0]) |-> !irq[0]);
endmodule

// File: tb/rcmp_top_tb.sv
module rcmp_top_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [2:0]  res_chan = '0;
   logic [9:0]  res_data = '0;
   logic [1:0]  cfg_we = '0;
   logic [19:0] cfg_data = '0;
   logic [1:0]  flag_clr = '0;
   logic [1:0]  flag, irq;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rcmp_top u_dut (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
      .res_data(res_data), .cfg_we(cfg_we), .cfg_data(cfg_data),
      .flag_clr(flag_clr), .flag(flag), .irq(irq)
   );

   // R2 layout: {n-1[19:16], thresh[15:6], chan[5:3], cond[2], ie[1], en[0]}
   function automatic logic [19:0] mk(input logic en, input logic ie, input logic cond,
                                      input logic [2:0] ch, input logic [9:0] thr,
                                      input int n);
      logic [3:0] m;
      m = 4'(n - 1);
      return {m, thr, ch, cond, ie, en};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg(input int u, input logic [19:0] w);
      @(negedge clk);
      cfg_we = '0; cfg_we[u] = 1'b1; cfg_data = w;
      @(negedge clk);
      cfg_we = '0;
   endtask

   task automatic push(input logic [2:0] ch, input logic [9:0] d);
      @(negedge clk);
      res_valid = 1'b1; res_chan = ch; res_data = d;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   task automatic clr(input int u);
      @(negedge clk);
      flag_clr = '0; flag_clr[u] = 1'b1;
      @(negedge clk);
      flag_clr = '0;
   endtask

   task automatic t_reset;
      check("R1 flag after reset", 32'(flag), 0);
      check("R1 irq after reset", 32'(irq), 0);
      push(3'd0, 10'd0);
      check("R1 reset config disabled", 32'(flag), 0);
   endtask

   task automatic t_run_ge;
      cfg(0, mk(1, 1, 1, 3'd3, 10'h200, 4));
      for (int i = 0; i < 3; i++) push(3'd3, 10'h200 + 10'(i));
      check("R4 no flag before Nth", 32'(flag[0]), 0);
      push(3'd3, 10'h3FF);
      check("R4 flag after Nth", 32'(flag[0]), 1);
      check("R9 irq with enable", 32'(irq[0]), 1);
      check("R11 other unit untouched", 32'(flag[1]), 0);
      clr(0);
      check("R8 clear", 32'(flag[0]), 0);
      check("R9 irq drops", 32'(irq[0]), 0);
   endtask

   task automatic t_fail_resets;
      cfg(0, mk(1, 0, 1, 3'd3, 10'h200, 4));
      push(3'd3, 10'h200); push(3'd3, 10'h201);
      push(3'd3, 10'h1FF);
      for (int i = 0; i < 3; i++) push(3'd3, 10'h250);
      check("R5 fail restarted run (R3 boundary)", 32'(flag[0]), 0);
      push(3'd3, 10'h250);
      check("R5 flag after full new run", 32'(flag[0]), 1);
      check("R9 irq gated off", 32'(irq[0]), 0);
      clr(0);
   endtask

   task automatic t_other_chan;
      cfg(0, mk(1, 0, 1, 3'd3, 10'h200, 4));
      push(3'd3, 10'h300); push(3'd3, 10'h300);
      push(3'd5, 10'h000); push(3'd2, 10'h3FF); push(3'd5, 10'h300);
      push(3'd3, 10'h300);
      check("R6 foreign results ignored", 32'(flag[0]), 0);
      push(3'd3, 10'h300);
      check("R6 count kept across foreign", 32'(flag[0]), 1);
      clr(0);
   endtask

   task automatic t_less;
      cfg(1, mk(1, 0, 0, 3'd0, 10'h010, 1));
      push(3'd0, 10'h010);
      check("R3 equal fails below test", 32'(flag[1]), 0);
      push(3'd0, 10'h00F);
      check("R3 below qualifies N=1", 32'(flag[1]), 1);
      check("R9 irq off when ie=0", 32'(irq[1]), 0);
      check("R11 unit0 unaffected", 32'(flag[0]), 0);
      clr(1);
      check("R8 unit1 cleared", 32'(flag[1]), 0);
   endtask

   task automatic t_restart;
      cfg(0, mk(1, 1, 1, 3'd1, 10'h100, 2));
      push(3'd1, 10'h100); push(3'd1, 10'h100);
      check("R4 N=2 flag", 32'(flag[0]), 1);
      push(3'd1, 10'h000); push(3'd1, 10'h000);
      check("R7 flag sticky over fails", 32'(flag[0]), 1);
      clr(0);
      push(3'd1, 10'h100);
      check("R7 run restarted after flag", 32'(flag[0]), 0);
      push(3'd1, 10'h100);
      check("R7 second run sets", 32'(flag[0]), 1);
      clr(0);
      // Raise with 1 leftover hit already counted? restart check: flag then one hit after
      push(3'd1, 10'h100); push(3'd1, 10'h100);
      clr(0);
      push(3'd1, 10'h100);
      check("R7 count zero after raise", 32'(flag[0]), 0);
      clr(0);
   endtask

   task automatic t_cfg_reset;
      cfg(0, mk(1, 0, 1, 3'd3, 10'h000, 3));
      push(3'd3, 10'h001); push(3'd3, 10'h001);
      cfg(0, mk(1, 0, 1, 3'd3, 10'h000, 3));
      push(3'd3, 10'h001);
      check("R10 write resets run", 32'(flag[0]), 0);
      push(3'd3, 10'h001);
      check("R10 still short", 32'(flag[0]), 0);
      push(3'd3, 10'h001);
      check("R10 full run after write", 32'(flag[0]), 1);
      clr(0);
      // result in same cycle as write not counted
      cfg(0, mk(1, 0, 1, 3'd3, 10'h000, 1));
      @(negedge clk);
      cfg_we = 2'b01; cfg_data = mk(1, 0, 1, 3'd3, 10'h000, 1);
      res_valid = 1'b1; res_chan = 3'd3; res_data = 10'h005;
      @(negedge clk);
      cfg_we = '0; res_valid = 1'b0;
      check("R10 result during write ignored", 32'(flag[0]), 0);
      cfg(0, mk(0, 1, 1, 3'd3, 10'h000, 1));
      push(3'd3, 10'h005);
      check("R10 disabled unit ignores", 32'(flag[0]), 0);
      cfg(0, 20'h0);
      push(3'd0, 10'h000);
      check("R10 zero config disabled", 32'(flag[0]), 0);
   endtask

   task automatic t_clr_race;
      cfg(1, mk(1, 1, 0, 3'd0, 10'h010, 1));
      push(3'd0, 10'h001);
      check("R4 unit1 set", 32'(flag[1]), 1);
      @(negedge clk);
      flag_clr = 2'b10; res_valid = 1'b1; res_chan = 3'd0; res_data = 10'h001;
      @(negedge clk);
      flag_clr = '0; res_valid = 1'b0;
      check("R8 set wins over clear", 32'(flag[1]), 1);
      clr(1);
      check("R8 clear alone", 32'(flag[1]), 0);
      check("R9 irq cleared", 32'(irq[1]), 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_run_ge();
      t_fail_resets();
      t_other_chan();
      t_less();
      t_restart();
      t_cfg_reset();
      t_clr_race();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule